// File: doc/BRIEF.md
# Processor Interrupt Entry Sequencer

This block holds the control registers that a small 32-bit core changes when it takes an interrupt. The registers are the program counter, the status word, the cause register and two pairs of save registers: one pair for the non-maskable path and one pair for the maskable path. Each cycle the block looks at three kinds of request: a reset request, a non-maskable request and six maskable sources. It picks at most one by fixed priority, saves the old PC and status word into the matching pair, steers the PC to that source's vector and records the source's cause code in its half of the cause register.

A non-maskable request that arrives while an earlier one is still in service is not lost. It is folded into a single pending bit, however many such requests arrive. A one-cycle return strobe ends non-maskable service. If the pending bit is set at that moment, the held request is taken on the following cycle. When nothing is accepted, the execution side can load PC and the status word through a write port. Each acceptance produces a one-cycle strobe and a 3-bit code that names the source taken.

Top module: `irq_entry_seq`

## Requirements
- R1: Synchronous reset `rst` clears PC, the cause register, all four save registers, the pending bit and the strobe, and loads the status word with 0x20.
- R2: A reset request wins over every other request. On the next edge it sets PC to 0, the status word to 0x20 and the cause register to 0, clears the pending bit, and pulses the strobe with code 0. The save registers keep their values.
- R3: A non-maskable request accepted while status bit 7 (in service) is clear copies PC and the status word into the non-maskable save pair and sets PC to 0x10. It sets status bits 7 and 5 (disable), clears status bit 6 (exception), writes 0x0010 into cause bits 31:16, keeps cause bits 15:0, and gives code 1. Status bit 5 does not block it.
- R4: A non-maskable request seen while status bit 7 is set is not serviced. It sets the pending bit and leaves PC and the non-maskable save pair unchanged. Repeated requests still leave only the single pending bit.
- R5: An accepted maskable source copies PC and the status word into the maskable save pair. It sets status bit 5, clears status bit 6, replaces cause bits 15:0 with the source's code and keeps cause bits 31:16.
- R6: Maskable source i (bit i of `mask_req`, i from 0 to 5) uses the vector 0x80 + 0x10·i for both its PC and its cause code, and reports code 2+i.
- R7: Priority runs reset request first, then a serviceable non-maskable request, then the maskable source with the lowest index.
- R8: Maskable requests have no effect while status bit 5 is set.
- R9: `nmi_ret` clears status bit 7. If the pending bit is set, or a non-maskable request is held in that same cycle, the pending bit clears and the non-maskable entry is taken on the next cycle.
- R10: In a cycle with no acceptance, `cpu_wr` loads `cpu_pc` and `cpu_psw`. In an accepting cycle the write is ignored and the saved values are the ones held before the edge. The strobe is high only for the cycle after an acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reset_req | input | 1 | Reset interrupt request |
| nmi_req | input | 1 | Non-maskable interrupt request |
| mask_req | input | 6 | Maskable source requests, bit 0 highest priority |
| nmi_ret | input | 1 | One-cycle end of non-maskable service |
| cpu_wr | input | 1 | Load PC and status word from the execution side |
| cpu_pc | input | 32 | PC value to load |
| cpu_psw | input | 32 | Status word value to load |
| pc | output | 32 | Program counter |
| psw | output | 32 | Status word |
| ecr | output | 32 | Cause register: 31:16 non-maskable, 15:0 maskable |
| fepc | output | 32 | Non-maskable saved PC |
| fepsw | output | 32 | Non-maskable saved status word |
| eipc | output | 32 | Maskable saved PC |
| eipsw | output | 32 | Maskable saved status word |
| nmi_pending | output | 1 | A non-maskable request is being held |
| take_stb | output | 1 | An interrupt was accepted on the last edge |
| take_code | output | 3 | Source accepted: 0 reset, 1 non-maskable, 2..7 maskable |

## Verification
The hardest state to reach from the ports is the deferred non-maskable entry. It needs an entry already in service, one or more further requests folded into the pending bit, and then the return strobe, after which the held entry must appear exactly one cycle later with no request present on the input. The stimulus table builds this state step by step, checking after each cycle that the pending bit and status bit 7 are where they should be. A directed test then covers the harder variant, in which a new request and the return strobe land in the same cycle. Because a blocked non-maskable request can coexist with an accepted maskable source, one row raises both together while the in-service bit is set, so that the pending bit and the maskable entry must both appear on the same edge.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    localparam int XLEN         = 32;
    localparam int HALF         = XLEN / 2;
    localparam int NUM_MASKABLE = 6;
    localparam int CODE_W       = 3;
    localparam int FIRST_MASK_CODE = 2;

    localparam int PSW_ID_BIT = 5;
    localparam int PSW_EP_BIT = 6;
    localparam int PSW_NP_BIT = 7;

    localparam logic [XLEN-1:0] PSW_AFTER_RESET = 32'h0000_0020;
    localparam logic [XLEN-1:0] NMI_VECTOR      = 32'h0000_0010;
    localparam logic [HALF-1:0] NMI_CAUSE       = 16'h0010;
    localparam logic [HALF-1:0] MASK_CAUSE_BASE = 16'h0080;
    localparam logic [HALF-1:0] MASK_CAUSE_STEP = 16'h0010;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_RESET = 2'd1,
        SRC_NMI   = 2'd2,
        SRC_MASK  = 2'd3
    } src_kind_e;

    typedef struct packed {
        src_kind_e         kind;
        logic [CODE_W-1:0] idx;
        logic              nmi_held;
    } arb_result_t;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] psw;
        logic [XLEN-1:0] ecr;
        logic [XLEN-1:0] fepc;
        logic [XLEN-1:0] fepsw;
        logic [XLEN-1:0] eipc;
        logic [XLEN-1:0] eipsw;
    } ctrl_regs_t;

    function automatic logic [HALF-1:0] mask_cause(input logic [CODE_W-1:0] idx);
        return MASK_CAUSE_BASE + MASK_CAUSE_STEP * HALF'(idx);
    endfunction

    function automatic logic [XLEN-1:0] mask_vector(input logic [CODE_W-1:0] idx);
        return {{(XLEN-HALF){1'b0}}, mask_cause(idx)};
    endfunction

    function automatic logic [CODE_W-1:0] source_code(input src_kind_e kind,
                                                      input logic [CODE_W-1:0] idx);
        case (kind)
            SRC_NMI:  return CODE_W'(1);
            SRC_MASK: return CODE_W'(FIRST_MASK_CODE) + idx;
            default:  return '0;
        endcase
    endfunction

endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_entry_pkg::*;
#(
    parameter int N_MASK = NUM_MASKABLE
) (
    input  logic              reset_req,
    input  logic              nmi_eff,
    input  logic              np_set,
    input  logic              id_set,
    input  logic [N_MASK-1:0] mask_req,
    output arb_result_t       res
);

    logic [N_MASK-1:0] first_hot;
    logic [CODE_W-1:0] hot_idx;

    generate
        for (genvar g = 0; g < N_MASK; g++) begin : g_first
            if (g == 0) begin : g_top
                assign first_hot[g] = mask_req[g];
            end else begin : g_rest
                assign first_hot[g] = mask_req[g] & ~(|mask_req[g-1:0]);
            end
        end
    endgenerate

    always_comb begin
        hot_idx = '0;
        for (int k = 0; k < N_MASK; k++) begin
            if (first_hot[k]) begin
                hot_idx = hot_idx | CODE_W'(k);
            end
        end
    end

    always_comb begin
        res.kind     = SRC_NONE;
        res.idx      = '0;
        res.nmi_held = 1'b0;
        if (reset_req) begin
            res.kind = SRC_RESET;
        end else begin
            res.nmi_held = nmi_eff & np_set;
            if (nmi_eff && !np_set) begin
                res.kind = SRC_NMI;
            end else if (!id_set && (|mask_req)) begin
                res.kind = SRC_MASK;
                res.idx  = hot_idx;
            end
        end
    end

endmodule

// File: rtl/irq_nmi_tracker.sv
module irq_nmi_tracker
    import irq_entry_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic reset_req,
    input  logic nmi_req,
    input  logic nmi_ret,
    input  logic nmi_held,
    output logic nmi_eff,
    output logic pending
);

    logic pending_q;
    logic replay_q;
    logic pending_d;
    logic replay_d;

    always_comb begin
        pending_d = pending_q;
        replay_d  = 1'b0;
        if (reset_req) begin
            pending_d = 1'b0;
        end else if (nmi_ret) begin
            replay_d  = pending_q | nmi_held;
            pending_d = 1'b0;
        end else if (nmi_held) begin
            pending_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q <= 1'b0;
            replay_q  <= 1'b0;
        end else begin
            pending_q <= pending_d;
            replay_q  <= replay_d;
        end
    end

    assign nmi_eff = nmi_req | replay_q;
    assign pending = pending_q;

endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
    import irq_entry_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  arb_result_t     sel,
    input  logic            cpu_wr,
    input  logic [XLEN-1:0] cpu_pc,
    input  logic [XLEN-1:0] cpu_psw,
    input  logic            nmi_ret,
    output ctrl_regs_t      q
);

    ctrl_regs_t cur;
    ctrl_regs_t nxt;
    logic [XLEN-1:0] entry_psw;

    always_comb begin
        entry_psw             = cur.psw;
        entry_psw[PSW_ID_BIT] = 1'b1;
        entry_psw[PSW_EP_BIT] = 1'b0;
    end

    always_comb begin
        nxt = cur;
        if (cpu_wr && sel.kind == SRC_NONE) begin
            nxt.pc  = cpu_pc;
            nxt.psw = cpu_psw;
        end
        case (sel.kind)
            SRC_RESET: begin
                nxt.pc  = '0;
                nxt.psw = PSW_AFTER_RESET;
                nxt.ecr = '0;
            end
            SRC_NMI: begin
                nxt.fepc              = cur.pc;
                nxt.fepsw             = cur.psw;
                nxt.pc                = NMI_VECTOR;
                nxt.psw               = entry_psw;
                nxt.psw[PSW_NP_BIT]   = 1'b1;
                nxt.ecr               = {NMI_CAUSE, cur.ecr[HALF-1:0]};
            end
            SRC_MASK: begin
                nxt.eipc  = cur.pc;
                nxt.eipsw = cur.psw;
                nxt.pc    = mask_vector(sel.idx);
                nxt.psw   = entry_psw;
                nxt.ecr   = {cur.ecr[XLEN-1:HALF], mask_cause(sel.idx)};
            end
            default: ;
        endcase
        if (nmi_ret && sel.kind != SRC_NMI) begin
            nxt.psw[PSW_NP_BIT] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur     <= '0;
            cur.psw <= PSW_AFTER_RESET;
        end else begin
            cur <= nxt;
        end
    end

    assign q = cur;

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int N_MASK = NUM_MASKABLE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reset_req,
    input  logic              nmi_req,
    input  logic [N_MASK-1:0] mask_req,
    input  logic              nmi_ret,
    input  logic              cpu_wr,
    input  logic [XLEN-1:0]   cpu_pc,
    input  logic [XLEN-1:0]   cpu_psw,
    output logic [XLEN-1:0]   pc,
    output logic [XLEN-1:0]   psw,
    output logic [XLEN-1:0]   ecr,
    output logic [XLEN-1:0]   fepc,
    output logic [XLEN-1:0]   fepsw,
    output logic [XLEN-1:0]   eipc,
    output logic [XLEN-1:0]   eipsw,
    output logic              nmi_pending,
    output logic              take_stb,
    output logic [CODE_W-1:0] take_code
);

    arb_result_t sel;
    ctrl_regs_t  regs;
    logic        nmi_eff;
    logic        stb_q;
    logic [CODE_W-1:0] code_q;

    irq_nmi_tracker u_tracker (
        .clk       (clk),
        .rst       (rst),
        .reset_req (reset_req),
        .nmi_req   (nmi_req),
        .nmi_ret   (nmi_ret),
        .nmi_held  (sel.nmi_held),
        .nmi_eff   (nmi_eff),
        .pending   (nmi_pending)
    );

    irq_arbiter #(.N_MASK(N_MASK)) u_arb (
        .reset_req (reset_req),
        .nmi_eff   (nmi_eff),
        .np_set    (regs.psw[PSW_NP_BIT]),
        .id_set    (regs.psw[PSW_ID_BIT]),
        .mask_req  (mask_req),
        .res       (sel)
    );

    irq_ctrl_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .sel     (sel),
        .cpu_wr  (cpu_wr),
        .cpu_pc  (cpu_pc),
        .cpu_psw (cpu_psw),
        .nmi_ret (nmi_ret),
        .q       (regs)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stb_q  <= 1'b0;
            code_q <= '0;
        end else begin
            stb_q  <= (sel.kind != SRC_NONE);
            code_q <= source_code(sel.kind, sel.idx);
        end
    end

    assign pc        = regs.pc;
    assign psw       = regs.psw;
    assign ecr       = regs.ecr;
    assign fepc      = regs.fepc;
    assign fepsw     = regs.fepsw;
    assign eipc      = regs.eipc;
    assign eipsw     = regs.eipsw;
    assign take_stb  = stb_q;
    assign take_code = code_q;

endmodule

// File: rtl/irq_entry_seq_checker.sv
module irq_entry_seq_checker
    import irq_entry_pkg::*;
#(
    parameter int N_MASK = NUM_MASKABLE
) (
    input logic              clk,
    input logic              rst,
    input logic              reset_req,
    input logic              nmi_req,
    input logic [N_MASK-1:0] mask_req,
    input logic              nmi_ret,
    input logic [XLEN-1:0]   pc,
    input logic [XLEN-1:0]   psw,
    input logic [XLEN-1:0]   ecr,
    input logic [XLEN-1:0]   fepc,
    input logic [XLEN-1:0]   fepsw,
    input logic              nmi_pending,
    input logic              take_stb,
    input logic [CODE_W-1:0] take_code
);

    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    // R1: state after a reset cycle
    always @(negedge clk) begin
        if (rst_d === 1'b1) begin
            a_r1_reset_state: assert (pc == '0 && psw == PSW_AFTER_RESET && ecr == '0
                                      && !nmi_pending && !take_stb);
        end
    end

    a_r2_reset_request: assert property (@(posedge clk) disable iff (rst)
        reset_req |=> (pc == '0 && psw == PSW_AFTER_RESET && ecr == '0
                       && !nmi_pending && take_stb && take_code == '0));

    a_r3_nmi_entry: assert property (@(posedge clk) disable iff (rst)
        (nmi_req && !psw[PSW_NP_BIT] && !reset_req) |=>
            (pc == NMI_VECTOR && psw[PSW_NP_BIT] && psw[PSW_ID_BIT] && !psw[PSW_EP_BIT]
             && fepc == $past(pc) && fepsw == $past(psw)
             && ecr[XLEN-1:HALF] == NMI_CAUSE && ecr[HALF-1:0] == $past(ecr[HALF-1:0])));

    a_r4_nmi_held: assert property (@(posedge clk) disable iff (rst)
        (nmi_req && psw[PSW_NP_BIT] && !reset_req && !nmi_ret) |=>
            (nmi_pending && fepc == $past(fepc)));

    a_r6_mask_vector: assert property (@(posedge clk) disable iff (rst)
        (take_stb && take_code >= CODE_W'(FIRST_MASK_CODE)) |->
            (pc == XLEN'(MASK_CAUSE_BASE) + XLEN'(MASK_CAUSE_STEP)
                   * XLEN'(take_code - CODE_W'(FIRST_MASK_CODE))
             && ecr[HALF-1:0] == pc[HALF-1:0]
             && psw[PSW_ID_BIT] && !psw[PSW_EP_BIT]));

    a_r8_masked_when_disabled: assert property (@(posedge clk) disable iff (rst)
        psw[PSW_ID_BIT] |=> !(take_stb && take_code >= CODE_W'(FIRST_MASK_CODE)));

    a_r9_return_clears: assert property (@(posedge clk) disable iff (rst)
        (nmi_ret && nmi_pending && !reset_req) |=> (!nmi_pending && !psw[PSW_NP_BIT]));

endmodule

bind irq_entry_seq irq_entry_seq_checker #(.N_MASK(N_MASK)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .reset_req   (reset_req),
    .nmi_req     (nmi_req),
    .mask_req    (mask_req),
    .nmi_ret     (nmi_ret),
    .pc          (pc),
    .psw         (psw),
    .ecr         (ecr),
    .fepc        (fepc),
    .fepsw       (fepsw),
    .nmi_pending (nmi_pending),
    .take_stb    (take_stb),
    .take_code   (take_code)
);

// File: tb/irq_entry_seq_bench.sv
`timescale 1ns/1ps
module irq_entry_seq_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reset_req = 1'b0;
    logic        nmi_req = 1'b0;
    logic [5:0]  mask_req = '0;
    logic        nmi_ret = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [31:0] cpu_pc = '0;
    logic [31:0] cpu_psw = '0;
    logic [31:0] pc, psw, ecr, fepc, fepsw, eipc, eipsw;
    logic        nmi_pending, take_stb;
    logic [2:0]  take_code;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    irq_entry_seq u_irq_entry_seq (
        .clk(clk), .rst(rst), .reset_req(reset_req), .nmi_req(nmi_req),
        .mask_req(mask_req), .nmi_ret(nmi_ret), .cpu_wr(cpu_wr),
        .cpu_pc(cpu_pc), .cpu_psw(cpu_psw), .pc(pc), .psw(psw), .ecr(ecr),
        .fepc(fepc), .fepsw(fepsw), .eipc(eipc), .eipsw(eipsw),
        .nmi_pending(nmi_pending), .take_stb(take_stb), .take_code(take_code)
    );

    typedef struct packed {
        logic        wr;
        logic [31:0] wpc;
        logic [31:0] wpsw;
        logic        rr;
        logic        nmi;
        logic [5:0]  msk;
        logic        ret;
        logic        stb;
        logic [2:0]  code;
        logic [31:0] e_pc;
        logic [31:0] e_psw;
        logic [31:0] e_ecr;
        logic        pend;
        logic [31:0] e_fepc;
        logic [31:0] e_fepsw;
        logic [31:0] e_eipc;
        logic [31:0] e_eipsw;
        logic [3:0]  tag;
    } row_t;

    localparam int NROWS = 19;
    localparam row_t TABLE [NROWS] = '{
        // R10: load PC/PSW with nothing pending
        '{1'b1, 32'h1000, 32'h00, 1'b0, 1'b0, 6'h00, 1'b0, 1'b0, 3'd0, 32'h1000, 32'h00, 32'h0, 1'b0, 32'h0, 32'h0, 32'h0, 32'h0, 4'd10},
        // R5: source 2 accepted, vector 0xA0
        '{1'b0, 32'h0, 32'h0, 1'b0, 1'b0, 6'h04, 1'b0, 1'b1, 3'd4, 32'hA0, 32'h20, 32'hA0, 1'b0, 32'h0, 32'h0, 32'h1000, 32'h0, 4'd5},
        // R8: all sources ignored while disable bit set
        '{1'b0, 32'h0, 32'h0, 1'b0, 1'b0, 6'h3F, 1'b0, 1'b0, 3'd0, 32'hA0, 32'h20, 32'hA0, 1'b0, 32'h0, 32'h0, 32'h1000, 32'h0, 4'd8},
        // R10: load PSW with exception bit set
        '{1'b1, 32'h2000, 32'h40, 1'b0, 1'b0, 6'h00, 1'b0, 1'b0, 3'd0, 32'h2000, 32'h40, 32'hA0, 1'b0, 32'h0, 32'h0, 32'h1000, 32'h0, 4'd10},
        // R7: sources 3 and 5, lower index wins; R5 exception bit cleared
        '{1'b0, 32'h0, 32'h0, 1'b0, 1'b0, 6'h28, 1'b0, 1'b1, 3'd5, 32'hB0, 32'h20, 32'hB0, 1'b0, 32'h0, 32'h0, 32'h2000, 32'h40, 4'd7},
        // R3: NMI taken despite disable bit, maskable cause kept
        '{1'b0, 32'h0, 32'h0, 1'b0, 1'b1, 6'h00, 1'b0, 1'b1, 3'd1, 32'h10, 32'hA0, 32'h1000B0, 1'b0, 32'hB0, 32'h20, 32'h2000, 32'h40, 4'd3},
        // R4: NMI in service, held
        '{1'b0, 32'h0, 32'h0, 1'b0, 1'b1, 6'h00, 1'b0, 1'b0, 3'd0, 32'h10, 32'hA0, 32'h1000B0, 1'b1, 32'hB0, 32'h20, 32'h2000, 32'h40, 4'd4},
        // R4: second held NMI not counted
        '{1'b0, 32'h0, 32'h0, 1'b0, 1'b1, 6'h00, 1'b0, 1'b0, 3'd0, 32'h10, 32'hA0, 32'h1000B0, 1'b1, 32'hB0, 32'h20, 32'h2000, 32'h40, 4'd4},
        // R9: return clears in-service bit and pending
        '{1'b0, 32'h0, 32'h0, 1'b0, 1'b0, 6'h00, 1'b1, 1'b0, 3'd0, 32'h10, 32'h20, 32'h1000B0, 1'b0, 32'hB0, 32'h20, 32'h2000, 32'h40, 4'd9},
        // R9: held NMI replayed with no request on the pin
        '{1'b0, 32'h0, 32'h0, 1'b0, 1'b0, 6'h00, 1'b0, 1'b1, 3'd1, 32'h10, 32'hA0, 32'h1000B0, 1'b0, 32'h10, 32'h20, 32'h2000, 32'h40, 4'd9},
        // R10: load in-service bit, disable clear
        '{1'b1, 32'h3000, 32'h80, 1'b0, 1'b0, 6'h00, 1'b0, 1'b0, 3'd0, 32'h3000, 32'h80, 32'h1000B0, 1'b0, 32'h10, 32'h20, 32'h2000, 32'h40, 4'd10},
        // R7: blocked NMI held while source 0 is taken
        '{1'b0, 32'h0, 32'h0, 1'b0, 1'b1, 6'h01, 1'b0, 1'b1, 3'd2, 32'h80, 32'hA0, 32'h100080, 1'b1, 32'h10, 32'h20, 32'h3000, 32'h80, 4'd7},
        // R2: reset request beats everything, clears pending
        '{1'b0, 32'h0, 32'h0, 1'b1, 1'b1, 6'h01, 1'b0, 1'b1, 3'd0, 32'h0, 32'h20, 32'h0, 1'b0, 32'h10, 32'h20, 32'h3000, 32'h80, 4'd2},
        // R10: load
        '{1'b1, 32'h4000, 32'h00, 1'b0, 1'b0, 6'h00, 1'b0, 1'b0, 3'd0, 32'h4000, 32'h00, 32'h0, 1'b0, 32'h10, 32'h20, 32'h3000, 32'h80, 4'd10},
        // R7: NMI beats source 4
        '{1'b0, 32'h0, 32'h0, 1'b0, 1'b1, 6'h10, 1'b0, 1'b1, 3'd1, 32'h10, 32'hA0, 32'h100000, 1'b0, 32'h4000, 32'h00, 32'h3000, 32'h80, 4'd7},
        // R9: return together with a load, bit 7 cleared after load
        '{1'b1, 32'h5000, 32'h80, 1'b0, 1'b0, 6'h00, 1'b1, 1'b0, 3'd0, 32'h5000, 32'h00, 32'h100000, 1'b0, 32'h4000, 32'h00, 32'h3000, 32'h80, 4'd9},
        // R6: source 5, vector 0xD0, code 7
        '{1'b0, 32'h0, 32'h0, 1'b0, 1'b0, 6'h20, 1'b0, 1'b1, 3'd7, 32'hD0, 32'h20, 32'h1000D0, 1'b0, 32'h4000, 32'h00, 32'h5000, 32'h00, 4'd6},
        // R8: source ignored, load takes effect
        '{1'b1, 32'h6000, 32'h00, 1'b0, 1'b0, 6'h20, 1'b0, 1'b0, 3'd0, 32'h6000, 32'h00, 32'h1000D0, 1'b0, 32'h4000, 32'h00, 32'h5000, 32'h00, 4'd8},
        // R10: accept overrides load, saved PC is the held one
        '{1'b1, 32'h7000, 32'h00, 1'b0, 1'b0, 6'h02, 1'b0, 1'b1, 3'd3, 32'h90, 32'h20, 32'h100090, 1'b0, 32'h4000, 32'h00, 32'h6000, 32'h00, 4'd10}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic step(input logic wr, input logic [31:0] wpc, input logic [31:0] wpsw,
                        input logic rr, input logic nmi, input logic [5:0] msk,
                        input logic ret);
        @(negedge clk);
        cpu_wr = wr; cpu_pc = wpc; cpu_psw = wpsw;
        reset_req = rr; nmi_req = nmi; mask_req = msk; nmi_ret = ret;
        @(posedge clk);
        #1;
        cpu_wr = 1'b0; reset_req = 1'b0; nmi_req = 1'b0; mask_req = '0; nmi_ret = 1'b0;
    endtask

    task automatic check_reset_state();
        check("R1 pc", pc, 32'h0);
        check("R1 psw", psw, 32'h20);
        check("R1 ecr", ecr, 32'h0);
        check("R1 fepc", fepc, 32'h0);
        check("R1 eipc", eipc, 32'h0);
        check("R1 pending", {31'b0, nmi_pending}, 32'h0);
        check("R1 strobe", {31'b0, take_stb}, 32'h0);
    endtask

    bit done = 1'b0;

    initial begin
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        rst = 1'b0;
        check_reset_state();

        for (int i = 0; i < NROWS; i++) begin
            row_t r;
            string t;
            r = TABLE[i];
            step(r.wr, r.wpc, r.wpsw, r.rr, r.nmi, r.msk, r.ret);
            t = $sformatf("R%0d row %0d", r.tag, i);
            check({t, " stb"},   {31'b0, take_stb}, {31'b0, r.stb});
            check({t, " code"},  {29'b0, take_code}, {29'b0, r.code});
            check({t, " pc"},    pc, r.e_pc);
            check({t, " psw"},   psw, r.e_psw);
            check({t, " ecr"},   ecr, r.e_ecr);
            check({t, " pend"},  {31'b0, nmi_pending}, {31'b0, r.pend});
            check({t, " fepc"},  fepc, r.e_fepc);
            check({t, " fepsw"}, fepsw, r.e_fepsw);
            check({t, " eipc"},  eipc, r.e_eipc);
            check({t, " eipsw"}, eipsw, r.e_eipsw);
        end

        // R1: synchronous reset in the middle of a run
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        rst = 1'b0;
        check_reset_state();

        // R9: new request and return strobe in the same cycle
        step(1'b1, 32'h100, 32'h80, 1'b0, 1'b0, 6'h00, 1'b0);
        step(1'b0, 32'h0, 32'h0, 1'b0, 1'b1, 6'h00, 1'b1);
        check("R9 same-cycle stb", {31'b0, take_stb}, 32'h0);
        check("R9 same-cycle psw", psw, 32'h00);
        check("R9 same-cycle pend", {31'b0, nmi_pending}, 32'h0);
        step(1'b0, 32'h0, 32'h0, 1'b0, 1'b0, 6'h00, 1'b0);
        check("R9 replay stb", {31'b0, take_stb}, 32'h1);
        check("R9 replay code", {29'b0, take_code}, 32'h1);
        check("R9 replay pc", pc, 32'h10);
        check("R9 replay fepc", fepc, 32'h100);
        check("R9 replay psw", psw, 32'hA0);

        // R10: strobe lasts one cycle
        step(1'b0, 32'h0, 32'h0, 1'b0, 1'b0, 6'h00, 1'b0);
        check("R10 strobe drop", {31'b0, take_stb}, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule